// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is the arithmetic and logic unit of a simple processor together with its local operation decoder. The main control supplies a 2-bit operation class; the instruction supplies a 6-bit function field. The local decoder turns these into a 3-bit operation code. The datapath then applies that code to two 32-bit operands and produces a 32-bit result and a zero flag.

Loads and stores use the add operation to form addresses. Branch-equal uses subtract, and the branch logic reads the zero flag as its equality test. Register-to-register instructions take their operation from the function field.

A single adder serves add, subtract and the signed comparison. The top bit of the operation code inverts operand B and injects a carry of one. The block is purely combinational and holds no state.

Top module: `twolevel_alu`

## Requirements
- R1: The operation code output takes only these values: 3'b010 add, 3'b110 subtract, 3'b000 AND, 3'b001 OR, 3'b111 set-on-less-than.
- R2: Operation class 2'b00 gives code 3'b010 (add) for every function field value.
- R3: Operation class 2'b01 gives code 3'b110 (subtract) for every function field value.
- R4: For operation class 2'b10 or 2'b11, function bits [3:0] select the operation: 4'b0000 add, 4'b0010 subtract, 4'b0100 AND, 4'b0101 OR, 4'b1010 set-on-less-than. Function bits [5:4] have no effect.
- R5: For class 2'b10 or 2'b11, any other value of function bits [3:0] gives add.
- R6: Add yields A+B mod 2^32, and subtract yields A-B mod 2^32 in two's complement.
- R7: AND and OR yield the bitwise AND and bitwise OR of A and B.
- R8: Set-on-less-than yields 1 when signed A is less than signed B, and 0 otherwise; result bits [31:1] are 0. The comparison is correct even when A-B overflows.
- R9: The zero output is 1 exactly when the 32-bit result is 0. Under subtract, zero is therefore 1 exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opClass | input | 2 | Operation class from the main control |
| funcField | input | 6 | Function field of the instruction |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| aluCode | output | 3 | Decoded operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when the result is zero |

## Verification
The block holds no state, so a decode fault shows up on the code output in the same cycle as the input that exposes it. The result and zero outputs show the fault in that cycle too. The bench therefore applies every class and function pairing and compares all three outputs against a behavioural model each cycle.

A fault in the negate path or in the comparison needs particular operands to become visible. The bench adds equal operands, operands that wrap around, and signed pairs whose difference overflows, so that such a fault changes the result or the zero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int FUNC_W = 6;
  localparam int CLASS_W = 2;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOp_e;

  // result source selection
  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_LT  = 2'b11
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    negateB;
    outSel_e outSel;
  } aluStrobe_t;

  localparam logic [3:0] FN_ADD = 4'b0000;
  localparam logic [3:0] FN_SUB = 4'b0010;
  localparam logic [3:0] FN_AND = 4'b0100;
  localparam logic [3:0] FN_OR  = 4'b0101;
  localparam logic [3:0] FN_SLT = 4'b1010;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
#(
  parameter int FUNC_WIDTH = FUNC_W
) (
  input  logic [CLASS_W-1:0]    opClass,
  input  logic [FUNC_WIDTH-1:0] funcField,
  output logic [CODE_W-1:0]     aluCode,
  output aluStrobe_t            strobe
);
  aluOp_e opSel;
  logic [3:0] funcLow;

  assign funcLow = funcField[3:0];

  always_comb begin
    if (opClass == 2'b00) begin
      opSel = OP_ADD;
    end else if (opClass == 2'b01) begin
      opSel = OP_SUB;
    end else begin
      case (funcLow)
        FN_ADD:  opSel = OP_ADD;
        FN_SUB:  opSel = OP_SUB;
        FN_AND:  opSel = OP_AND;
        FN_OR:   opSel = OP_OR;
        FN_SLT:  opSel = OP_SLT;
        default: opSel = OP_ADD;
      endcase
    end
  end

  assign aluCode        = opSel;
  assign strobe.negateB = opSel[2];
  assign strobe.outSel  = outSel_e'(opSel[1:0]);

  always_comb begin
    if (opClass == 2'b00)
      p_class_mem_add_r2: assert (aluCode == 3'b010);
    if (opClass == 2'b01)
      p_class_branch_sub_r3: assert (aluCode == 3'b110);
    p_code_legal_r1: assert (aluCode == 3'b000 || aluCode == 3'b001 ||
                             aluCode == 3'b010 || aluCode == 3'b110 ||
                             aluCode == 3'b111);
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bOperand;
  logic [WIDTH-1:0] carryIn;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] andVal;
  logic [WIDTH-1:0] orVal;
  logic             signDiffer;
  logic             lessThan;

  // per-bit logic slice
  for (genvar i = 0; i < WIDTH; i++) begin : g_logic
    assign andVal[i]   = opA[i] & opB[i];
    assign orVal[i]    = opA[i] | opB[i];
    assign bOperand[i] = opB[i] ^ strobe.negateB;
  end

  assign carryIn = {{(WIDTH-1){1'b0}}, strobe.negateB};
  assign sum     = opA + bOperand + carryIn;

  // signed compare: operand signs decide when they differ, so overflow
  // of the subtraction never corrupts the answer
  assign signDiffer = opA[MSB] ^ opB[MSB];
  assign lessThan   = signDiffer ? opA[MSB] : sum[MSB];

  always_comb begin
    case (strobe.outSel)
      SEL_AND: result = andVal;
      SEL_OR:  result = orVal;
      SEL_SUM: result = sum;
      default: result = {{(WIDTH-1){1'b0}}, lessThan};
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (strobe.outSel == SEL_SUM && !strobe.negateB)
      p_add_inverse_r6: assert (result - opB == opA);
    if (strobe.outSel == SEL_SUM && strobe.negateB)
      p_sub_equal_zero_r9: assert (zero == (opA == opB));
    if (strobe.outSel == SEL_LT)
      p_slt_upper_clear_r8: assert (result[MSB:1] == '0);
    if (strobe.outSel == SEL_AND)
      p_and_subset_r7: assert ((result & ~opA) == '0);
  end
endmodule

// File: rtl/twolevel_alu.sv
module twolevel_alu
  import alu_pkg::*;
(
  input  logic [1:0]  opClass,
  input  logic [5:0]  funcField,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [2:0]  aluCode,
  output logic [31:0] result,
  output logic        zero
);
  aluStrobe_t strobe;

  alu_decode #(.FUNC_WIDTH(FUNC_W)) u_dec (
    .opClass  (opClass),
    .funcField(funcField),
    .aluCode  (aluCode),
    .strobe   (strobe)
  );

  alu_datapath #(.WIDTH(DATA_W)) u_dp (
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .result(result),
    .zero  (zero)
  );
endmodule

// File: tb/sim_twolevel_alu.sv
`timescale 1ns/1ps
module sim_twolevel_alu;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]  opClass = '0;
  logic [5:0]  funcField = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  aluCode;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  twolevel_alu u0 (
    .opClass(opClass), .funcField(funcField), .opA(opA), .opB(opB),
    .aluCode(aluCode), .result(result), .zero(zero)
  );

  function automatic logic [2:0] refCode(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'd0) return 3'b010;
    if (c == 2'd1) return 3'b110;
    if (f[3:0] == 4'd0)  return 3'b010;
    if (f[3:0] == 4'd2)  return 3'b110;
    if (f[3:0] == 4'd4)  return 3'b000;
    if (f[3:0] == 4'd5)  return 3'b001;
    if (f[3:0] == 4'd10) return 3'b111;
    return 3'b010;
  endfunction

  function automatic logic [31:0] refResult(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (k == 3'b000) return a & b;
    if (k == 3'b001) return a | b;
    if (k == 3'b110) return a - b;
    if (k == 3'b111) return (sa < sb) ? 32'd1 : 32'd0;
    return a + b;
  endfunction

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic checkOne(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (class=%0d func=%b a=%h b=%h)",
               tag, what, act, exp, opClass, funcField, opA, opB);
    end
  endtask

  task automatic applyVec(input string tag, input logic [1:0] c, input logic [5:0] f,
                          input logic [31:0] a, input logic [31:0] b);
    logic [2:0]  ek;
    logic [31:0] er;
    @(negedge clk);
    opClass = c; funcField = f; opA = a; opB = b;
    @(posedge clk);
    #1;
    ek = refCode(c, f);
    er = refResult(ek, a, b);
    checkOne(tag, 64'(aluCode), 64'(ek), "code");
    checkOne(tag, 64'(result), 64'(er), "result");
    checkOne(tag, 64'(zero), 64'(er == 32'd0), "zero");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    // idle inputs: class 0 add of zeros
    #1;
    checkOne("R2", 64'(aluCode), 64'(3'b010), "idle code");
    checkOne("R9", 64'(zero), 64'd1, "idle zero");

    // every class and function pairing, two operand sets each
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 64; f++) begin
        string tag;
        logic [3:0] lo;
        lo = 4'(f);
        if (c == 0) tag = "R2";
        else if (c == 1) tag = "R3";
        else if (lo == 4'd0 || lo == 4'd2 || lo == 4'd4 || lo == 4'd5 || lo == 4'd10) tag = "R4";
        else tag = "R5";
        applyVec(tag, 2'(c), 6'(f), nextRand(), nextRand());
        applyVec(tag, 2'(c), 6'(f), nextRand(), nextRand());
      end
    end

    // R6 wrap-around add and subtract
    applyVec("R6", 2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h0000_0001);
    applyVec("R6", 2'b10, 6'b100010, 32'h0000_0000, 32'h0000_0001);
    // R7 bitwise
    applyVec("R7", 2'b10, 6'b100100, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    applyVec("R7", 2'b11, 6'b010101, 32'hF0F0_0000, 32'h0000_000F);
    // R8 signed compare with overflow
    applyVec("R8", 2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000);
    applyVec("R8", 2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001);
    applyVec("R8", 2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0000);
    applyVec("R8", 2'b10, 6'b101010, 32'h0000_0005, 32'h0000_0005);
    // R9 branch equality
    applyVec("R9", 2'b01, 6'b111111, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    applyVec("R9", 2'b01, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
    // R1 code values named directly
    applyVec("R1", 2'b11, 6'b001010, 32'h1, 32'h2);
    applyVec("R1", 2'b10, 6'b110101, 32'h1, 32'h2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule